// File: doc/BRIEF.md
# SPI Slave Hold Pause Controller

This block sits beside the serial shift logic of an SPI slave and lets the bus master pause a transaction without deselecting the slave. The serial clock, the active-low select and the active-low pause request arrive from pins. They are resynchronised into a fast system clock, and all decisions are made on the synchronised copies.

While a pause is in force, the block does three things. It raises a flag that freezes the shift register and bit counter. It withdraws the output enable of the serial data pin. It suppresses the per-edge strobes that would otherwise advance the shift logic.

A pause starts or ends only while the serial clock is low. A pause request edge that arrives while the clock is high takes effect at the next clock low phase. Releasing the select in any selected state ends the transaction with a one-cycle reset pulse. The slave then stays deselected until the select falls again while the pause request is released. Both idle clock levels (Mode 0 and Mode 3) are handled, because only edges of the serial clock are used.

Top module: `spi_hold_ctrl`

## Requirements
- R1: During and after a synchronous reset with select high, the pause flag, output enable, both strobes and the transaction reset pulse are all low.
- R2: Each pin passes through a two-flop synchroniser. A pause request falling edge, applied with the clock low in a running transaction, raises the pause flag on the third system clock edge after the change and not on the second.
- R3: A pause can only begin while the slave is selected. With select high, the pause request has no effect on the pause flag.
- R4: A pause request falling edge seen while the serial clock is low starts the pause at once. If the clock is high at that edge, the pause starts when the clock next goes low, and no output strobe fires for that falling clock edge.
- R5: A pause request rising edge seen while the serial clock is low ends the pause at once. If the clock is high at that edge, the pause flag stays high until the clock next goes low.
- R6: While the pause flag is high, the output enable is low and no sample or drive strobe fires, whatever the serial clock does.
- R7: The pause flag stays high for as long as the pause request stays low and select stays low.
- R8: A rising edge of select, while the slave is selected, produces exactly one one-cycle transaction reset pulse and clears the pause. The slave becomes selected again only on a later select falling edge that occurs with the pause request high.
- R9: In a running transaction, every serial clock rising edge gives exactly one sample strobe, and every falling edge gives exactly one drive strobe. This holds with both Mode 0 and Mode 3 idle levels.
- R10: The output enable is high while the slave is selected and not paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| cs_n_i | input | 1 | Slave select pin, active low, asynchronous |
| hold_n_i | input | 1 | Pause request pin, active low, asynchronous |
| hold_active_o | output | 1 | Pause in force; freezes shift register and bit counter |
| so_oe_o | output | 1 | Output enable for the serial data pin |
| sample_en_o | output | 1 | One-cycle strobe per serial clock rising edge while running |
| drive_en_o | output | 1 | One-cycle strobe per serial clock falling edge while running |
| xact_rst_o | output | 1 | One-cycle pulse resetting transaction state on deselect |

## Verification
The bench sweeps all four combinations of serial clock level at the moment of pause entry and at the moment of pause exit. This separates immediate transitions from deferred ones. Full bytes of clocking in both idle levels show that strobe counts match edge counts, and clocking during a pause shows that the strobes are suppressed. A deselect during a pause, followed by reselection with the request still low and then with it released, distinguishes a correct interface reset from a silent resume. A cycle-exact probe of the pause flag pins down the synchroniser depth.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic [2:0] {
        ST_DESEL      = 3'd0,
        ST_RUN        = 3'd1,
        ST_ENTER_WAIT = 3'd2,
        ST_HOLD       = 3'd3,
        ST_EXIT_WAIT  = 3'd4
    } hold_state_e;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic hold_n;
    } pins_t;

    localparam int    PIN_W    = $bits(pins_t);
    localparam pins_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, hold_n: 1'b1};

    function automatic logic is_held(hold_state_e st);
        return (st == ST_HOLD) || (st == ST_EXIT_WAIT);
    endfunction

    function automatic logic is_free(hold_state_e st);
        return (st == ST_RUN) || (st == ST_ENTER_WAIT);
    endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hold_edge.sv
module hold_edge #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= cur_i;
    end

    assign rise_o = cur_i & ~prev_q;
    assign fall_o = ~cur_i & prev_q;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        hold_n,
    input  logic        cs_fall,
    input  logic        hold_fall,
    input  logic        hold_rise,
    output hold_state_e state_o
);
    hold_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_DESEL;
        end else begin
            unique case (state_q)
                ST_DESEL: begin
                    if (cs_fall && hold_n) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (hold_fall) state_d = sck ? ST_ENTER_WAIT : ST_HOLD;
                end
                ST_ENTER_WAIT: begin
                    if (!sck) state_d = hold_n ? ST_RUN : ST_HOLD;
                end
                ST_HOLD: begin
                    if (hold_rise) state_d = sck ? ST_EXIT_WAIT : ST_RUN;
                end
                ST_EXIT_WAIT: begin
                    if (!sck) state_d = hold_n ? ST_RUN : ST_HOLD;
                end
                default: state_d = ST_DESEL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DESEL;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic hold_n_i,
    output logic hold_active_o,
    output logic so_oe_o,
    output logic sample_en_o,
    output logic drive_en_o,
    output logic xact_rst_o
);
    pins_t       raw_pins;
    pins_t       s_pins;
    pins_t       rise_p;
    pins_t       fall_p;
    hold_state_e state_q;
    logic        s_sck;
    logic        s_cs_n;
    logic        s_hold_n;
    logic        running;

    assign raw_pins = '{sck: sck_i, cs_n: cs_n_i, hold_n: hold_n_i};

    hold_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_pins),
        .q_o (s_pins)
    );

    hold_edge #(
        .W       (PIN_W),
        .RST_VAL (PIN_IDLE)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (s_pins),
        .rise_o (rise_p),
        .fall_o (fall_p)
    );

    assign s_sck    = s_pins.sck;
    assign s_cs_n   = s_pins.cs_n;
    assign s_hold_n = s_pins.hold_n;

    hold_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sck       (s_sck),
        .cs_n      (s_cs_n),
        .hold_n    (s_hold_n),
        .cs_fall   (fall_p.cs_n),
        .hold_fall (fall_p.hold_n),
        .hold_rise (rise_p.hold_n),
        .state_o   (state_q)
    );

    assign running       = (state_q == ST_RUN) && !s_cs_n;
    assign hold_active_o = is_held(state_q);
    assign so_oe_o       = is_free(state_q) && !s_cs_n;
    assign sample_en_o   = running && rise_p.sck;
    assign drive_en_o    = running && fall_p.sck;
    assign xact_rst_o    = rise_p.cs_n && (state_q != ST_DESEL);
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic s_sck,
    input logic s_cs_n,
    input logic s_hold_n,
    input logic hold_active,
    input logic so_oe,
    input logic sample_en,
    input logic drive_en,
    input logic xact_rst
);
    a_r3_enter_only_selected: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_active) |-> $past(!s_cs_n));

    a_r4_enter_on_sck_low: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_active) |-> $past(!s_sck));

    a_r5_exit_on_sck_low: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_active) |-> ($past(!s_sck) || $past(s_cs_n)));

    a_r6_quiet_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> (!so_oe && !sample_en && !drive_en));

    a_r7_hold_persists: assert property (@(posedge clk) disable iff (rst)
        (hold_active && !s_hold_n && !s_cs_n) |=> hold_active);

    a_r8_single_reset_pulse: assert property (@(posedge clk) disable iff (rst)
        xact_rst |=> !xact_rst);

    a_r8_reset_clears_hold: assert property (@(posedge clk) disable iff (rst)
        xact_rst |=> !hold_active);

    a_r9_one_strobe_per_cycle: assert property (@(posedge clk) disable iff (rst)
        !(sample_en && drive_en));
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .s_sck       (s_sck),
    .s_cs_n      (s_cs_n),
    .s_hold_n    (s_hold_n),
    .hold_active (hold_active_o),
    .so_oe       (so_oe_o),
    .sample_en   (sample_en_o),
    .drive_en    (drive_en_o),
    .xact_rst    (xact_rst_o)
);

// File: tb/test_spi_hold_ctrl.sv
module test_spi_hold_ctrl;
    localparam time CLK_P = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic hold_n = 1'b1;
    logic hold_active, so_oe, sample_en, drive_en, xact_rst;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt_s    = 0;
    int cnt_d    = 0;
    int cnt_r    = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    spi_hold_ctrl i_spi_hold_ctrl (
        .clk           (clk),
        .rst           (rst),
        .sck_i         (sck),
        .cs_n_i        (cs_n),
        .hold_n_i      (hold_n),
        .hold_active_o (hold_active),
        .so_oe_o       (so_oe),
        .sample_en_o   (sample_en),
        .drive_en_o    (drive_en),
        .xact_rst_o    (xact_rst)
    );

    always @(negedge clk) begin
        if (sample_en) cnt_s++;
        if (drive_en)  cnt_d++;
        if (xact_rst)  cnt_r++;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        cnt_s = 0; cnt_d = 0; cnt_r = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(4);
        // R1 reset state
        chk("R1 hold", hold_active, 0);
        chk("R1 oe", so_oe, 0);
        chk("R1 strobes", cnt_s + cnt_d + cnt_r, 0);

        // R10 select in Mode 0
        cs_n = 1'b0;
        wait_cyc(4);
        chk("R10 oe selected", so_oe, 1);
        chk("R10 not held", hold_active, 0);

        // R9 Mode 0 byte
        clr_counts();
        for (int b = 0; b < 8; b++) begin
            sck = 1'b1; wait_cyc(4);
            sck = 1'b0; wait_cyc(4);
        end
        chk("R9 mode0 samples", cnt_s, 8);
        chk("R9 mode0 drives", cnt_d, 8);

        // R2 synchroniser latency
        hold_n = 1'b0;
        wait_cyc(2);
        chk("R2 not yet held", hold_active, 0);
        wait_cyc(1);
        chk("R2 held on third edge", hold_active, 1);

        // R6 clocking ignored in hold
        clr_counts();
        for (int b = 0; b < 5; b++) begin
            sck = 1'b1; wait_cyc(4);
            sck = 1'b0; wait_cyc(4);
        end
        chk("R6 no strobes", cnt_s + cnt_d, 0);
        chk("R6 oe off", so_oe, 0);

        // R7 persistence
        wait_cyc(200);
        chk("R7 still held", hold_active, 1);

        // R5 direct exit
        hold_n = 1'b1;
        wait_cyc(4);
        chk("R5 direct exit", hold_active, 0);
        chk("R10 oe back", so_oe, 1);

        // R4/R5 sweep over clock level at entry and exit
        for (int ent = 0; ent < 2; ent++) begin
            for (int ex = 0; ex < 2; ex++) begin
                sck = logic'(ent); wait_cyc(4);
                clr_counts();
                hold_n = 1'b0; wait_cyc(6);
                chk("R4 entry at level", hold_active, (ent == 0) ? 1 : 0);
                if (ent == 1) begin
                    sck = 1'b0; wait_cyc(4);
                    chk("R4 deferred entry", hold_active, 1);
                    chk("R4 no drive at entry fall", cnt_d, 0);
                end
                sck = logic'(ex); wait_cyc(4);
                hold_n = 1'b1; wait_cyc(6);
                chk("R5 exit at level", hold_active, (ex == 1) ? 1 : 0);
                if (ex == 1) begin
                    sck = 1'b0; wait_cyc(4);
                    chk("R5 deferred exit", hold_active, 0);
                end
                clr_counts();
                sck = 1'b1; wait_cyc(4);
                sck = 1'b0; wait_cyc(4);
                chk("R9 resumes after pause", cnt_s, 1);
            end
        end

        // R8 deselect during hold
        hold_n = 1'b0; wait_cyc(4);
        chk("R8 pre hold", hold_active, 1);
        clr_counts();
        cs_n = 1'b1; wait_cyc(4);
        chk("R8 one reset pulse", cnt_r, 1);
        chk("R8 hold cleared", hold_active, 0);
        chk("R8 oe off", so_oe, 0);
        cs_n = 1'b0; wait_cyc(4);
        chk("R8 reselect with hold low refused", so_oe, 0);
        sck = 1'b1; wait_cyc(4);
        sck = 1'b0; wait_cyc(4);
        chk("R8 no strobes while refused", cnt_s + cnt_d, 0);
        hold_n = 1'b1; wait_cyc(4);
        chk("R8 needs new select edge", so_oe, 0);
        cs_n = 1'b1; wait_cyc(4);
        chk("R8 no pulse when unselected", cnt_r, 1);
        cs_n = 1'b0; wait_cyc(4);
        chk("R8 new select accepted", so_oe, 1);

        // R3 hold ignored when deselected
        cs_n = 1'b1; wait_cyc(4);
        hold_n = 1'b0; wait_cyc(6);
        chk("R3 no hold deselected", hold_active, 0);
        hold_n = 1'b1; wait_cyc(4);

        // R9 Mode 3 byte
        sck = 1'b1; wait_cyc(4);
        cs_n = 1'b0; wait_cyc(4);
        clr_counts();
        for (int b = 0; b < 8; b++) begin
            sck = 1'b0; wait_cyc(4);
            sck = 1'b1; wait_cyc(4);
        end
        chk("R9 mode3 samples", cnt_s, 8);
        chk("R9 mode3 drives", cnt_d, 8);
        cs_n = 1'b1; wait_cyc(4);

        finish_run();
    end
endmodule